// File: doc/BRIEF.md
# Four-Bit Single-Cycle Processor Core

This block is a small single-cycle processor that works on 4-bit data. Its program lives in a read-only store that is set through a parameter. The store holds one 12-bit instruction per program-counter value. On every rising clock edge the core executes the instruction the program counter points at. It then writes a register, updates the flags, or redirects the program counter. Eight 4-bit general registers are provided, and register 0 always reads as zero. Arithmetic and logic run in a separate ALU, which a 4-bit function code selects.

The decoder sorts each instruction into one of four named classes by its top two bits: OPC_ALU (00), OPC_NEG (01), OPC_LDI (10) and OPC_JZ (11). The program counter has three named transitions. STEP adds one and wraps from 7 to 0. JUMP loads the target field when a tested register is zero. CLEAR returns it to 0 on reset. A debug port shows any chosen register, the program counter and the overflow and zero flags, so that a program's progress can be watched.

Top module: `np_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, every register and both flags to 0 on the rising edge where `rst` is high.
- R2: Class OPC_LDI (bits 11:10 = 10) writes the immediate in bits 3:0 into the register named by bits 9:7. Both flags stay unchanged.
- R3: Class OPC_ALU (bits 11:10 = 00) combines Ra (bits 9:7) and Rb (bits 6:4) and writes the result back to Ra. The function code in bits 3:0 selects the operation: 0000 add, 0001 subtract Ra-Rb, 0010 AND, 0011 OR, 0100 XOR, 0101 the low nibble of the unsigned product.
- R4: Function code 0111 is a compare. It computes Ra-Rb and updates the flags, but writes no register.
- R5: Class OPC_NEG (bits 11:10 = 01) replaces the register named by bits 9:7 with its two's-complement negation.
- R6: OPC_ALU and OPC_NEG instructions update both flags. The zero flag is set when the 4-bit result is 0. The overflow flag is set for signed overflow on add, subtract, compare and negate, and when the upper nibble of the product is non-zero on multiply. It is cleared for the logic operations. OPC_LDI and OPC_JZ leave both flags unchanged.
- R7: Class OPC_JZ (bits 11:10 = 11) tests the register named by bits 9:7. If that register is zero, the program counter loads bits 2:0 (JUMP). Otherwise it takes STEP.
- R8: When no jump is taken, the program counter adds one per clock and wraps from 7 to 0.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: `dbg_val` shows the register selected by `dbg_sel` combinationally. `pc_o`, `ovf_o` and `zero_o` show the current program counter and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sel | input | 3 | Register number shown on `dbg_val` |
| dbg_val | output | 4 | Contents of the selected register |
| pc_o | output | 3 | Current program counter |
| ovf_o | output | 1 | Overflow flag |
| zero_o | output | 1 | Zero flag |

## Verification
The assertions assume that `rst` is high from time zero until the first few edges have passed. They also assume that `dbg_sel` changes only away from the rising edge, because the register-zero property samples it together with `dbg_val`. The bench holds reset across three edges before it releases it. It drives `dbg_sel` only on falling edges. Two instances run fixed programs that reach every instruction class, including a taken jump, a fall-through jump, a discarded write to register 0, multiply and add overflow, and a compare that clears nothing but the flags.

// File: rtl/np_pkg.sv
package np_pkg;

    typedef enum logic [1:0] {
        OPC_ALU = 2'b00,
        OPC_NEG = 2'b01,
        OPC_LDI = 2'b10,
        OPC_JZ  = 2'b11
    } op_class_e;

    localparam logic [3:0] FN_ADD = 4'b0000;
    localparam logic [3:0] FN_SUB = 4'b0001;
    localparam logic [3:0] FN_AND = 4'b0010;
    localparam logic [3:0] FN_OR  = 4'b0011;
    localparam logic [3:0] FN_XOR = 4'b0100;
    localparam logic [3:0] FN_MUL = 4'b0101;
    localparam logic [3:0] FN_CMP = 4'b0111;

endpackage

// File: rtl/np_alu.sv
module np_alu
    import np_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fn,
    output logic [W-1:0] y,
    output logic         ovf
);

    logic [W-1:0]   sum;
    logic [W-1:0]   diff;
    logic [2*W-1:0] prod;
    logic           add_ovf;
    logic           sub_ovf;

    assign sum     = a + b;
    assign diff    = a - b;
    assign prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign add_ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    assign sub_ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);

    always_comb begin
        unique case (fn)
            FN_ADD: begin y = sum;          ovf = add_ovf;          end
            FN_SUB,
            FN_CMP: begin y = diff;         ovf = sub_ovf;          end
            FN_AND: begin y = a & b;        ovf = 1'b0;             end
            FN_OR:  begin y = a | b;        ovf = 1'b0;             end
            FN_XOR: begin y = a ^ b;        ovf = 1'b0;             end
            FN_MUL: begin y = prod[W-1:0];  ovf = |prod[2*W-1:W];   end
            default: begin y = a;           ovf = 1'b0;             end
        endcase
    end

endmodule

// File: rtl/np_regfile.sv
module np_regfile #(
    parameter int W      = 4,
    parameter int N_REGS = 8,
    localparam int AW    = $clog2(N_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_d,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_d
);

    logic [W-1:0] mem [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign mem[g] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && (wa == AW'(g))) begin
                    q <= wd;
                end
            end
            assign mem[g] = q;
        end
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
    assign rd_d = mem[ra_d];

endmodule

// File: rtl/np_decode.sv
module np_decode
    import np_pkg::*;
#(
    parameter int IW    = 12,
    parameter int AW    = 3,
    parameter int W     = 4,
    parameter int PC_W  = 3,
    localparam int RA_LO = IW - 2 - AW,
    localparam int RB_LO = RA_LO - AW
) (
    input  logic [IW-1:0]   instr,
    output logic [AW-1:0]   rd_a_addr,
    output logic [AW-1:0]   rd_b_addr,
    output logic [3:0]      alu_fn,
    output logic [W-1:0]    imm,
    output logic [PC_W-1:0] tgt,
    output logic            wb_en,
    output logic            wb_imm,
    output logic            flag_en,
    output logic            zero_a,
    output logic            is_jz
);

    op_class_e    op;
    logic [AW-1:0] ra_f;
    logic [AW-1:0] rb_f;
    logic [3:0]    fn_f;

    assign op        = op_class_e'(instr[IW-1:IW-2]);
    assign ra_f      = instr[RA_LO +: AW];
    assign rb_f      = instr[RB_LO +: AW];
    assign fn_f      = instr[3:0];
    assign imm       = instr[W-1:0];
    assign tgt       = instr[PC_W-1:0];
    assign rd_a_addr = ra_f;

    always_comb begin
        rd_b_addr = rb_f;
        alu_fn    = fn_f;
        wb_en     = 1'b0;
        wb_imm    = 1'b0;
        flag_en   = 1'b0;
        zero_a    = 1'b0;
        is_jz     = 1'b0;
        unique case (op)
            OPC_ALU: begin
                wb_en   = (fn_f != FN_CMP);
                flag_en = 1'b1;
            end
            OPC_NEG: begin
                rd_b_addr = ra_f;
                alu_fn    = FN_SUB;
                zero_a    = 1'b1;
                wb_en     = 1'b1;
                flag_en   = 1'b1;
            end
            OPC_LDI: begin
                wb_en  = 1'b1;
                wb_imm = 1'b1;
            end
            OPC_JZ: begin
                is_jz = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/np_core.sv
module np_core
    import np_pkg::*;
#(
    parameter int W      = 4,
    parameter int N_REGS = 8,
    parameter int PC_W   = 3,
    parameter int IW     = 12,
    localparam int AW    = $clog2(N_REGS),
    localparam int DEPTH = 1 << PC_W,
    parameter logic [IW*DEPTH-1:0] PROGRAM = {
        12'hC80, 12'h809, 12'hA0F, 12'hD86,
        12'h500, 12'h0A0, 12'h903, 12'h885
    }
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   dbg_sel,
    output logic [W-1:0]    dbg_val,
    output logic [PC_W-1:0] pc_o,
    output logic            ovf_o,
    output logic            zero_o
);

    logic [PC_W-1:0] pc_q, pc_d;
    logic            ovf_q, ovf_d;
    logic            zero_q, zero_d;

    logic [IW-1:0]   instr;
    logic [AW-1:0]   rd_a_addr, rd_b_addr;
    logic [3:0]      alu_fn;
    logic [W-1:0]    imm;
    logic [PC_W-1:0] tgt;
    logic            wb_en, wb_imm, flag_en, zero_a, is_jz;
    logic [W-1:0]    ra_val, rb_val, alu_a, alu_y, wb_data;
    logic            alu_ovf;
    logic            jump_take;

    assign instr = PROGRAM[int'(pc_q)*IW +: IW];

    np_decode #(.IW(IW), .AW(AW), .W(W), .PC_W(PC_W)) u_dec (
        .instr     (instr),
        .rd_a_addr (rd_a_addr),
        .rd_b_addr (rd_b_addr),
        .alu_fn    (alu_fn),
        .imm       (imm),
        .tgt       (tgt),
        .wb_en     (wb_en),
        .wb_imm    (wb_imm),
        .flag_en   (flag_en),
        .zero_a    (zero_a),
        .is_jz     (is_jz)
    );

    np_regfile #(.W(W), .N_REGS(N_REGS)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we   (wb_en),
        .wa   (rd_a_addr),
        .wd   (wb_data),
        .ra_a (rd_a_addr),
        .ra_b (rd_b_addr),
        .ra_d (dbg_sel),
        .rd_a (ra_val),
        .rd_b (rb_val),
        .rd_d (dbg_val)
    );

    assign alu_a = zero_a ? '0 : ra_val;

    np_alu #(.W(W)) u_alu (
        .a   (alu_a),
        .b   (rb_val),
        .fn  (alu_fn),
        .y   (alu_y),
        .ovf (alu_ovf)
    );

    assign wb_data   = wb_imm ? imm : alu_y;
    assign jump_take = is_jz && (ra_val == '0);

    // next-state process
    always_comb begin
        pc_d   = jump_take ? tgt : pc_q + PC_W'(1);
        ovf_d  = ovf_q;
        zero_d = zero_q;
        if (flag_en) begin
            ovf_d  = alu_ovf;
            zero_d = (alu_y == '0);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ovf_q  <= 1'b0;
            zero_q <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            ovf_q  <= ovf_d;
            zero_q <= zero_d;
        end
    end

    assign pc_o   = pc_q;
    assign ovf_o  = ovf_q;
    assign zero_o = zero_q;

endmodule

// File: rtl/np_core_chk.sv
module np_core_chk #(
    parameter int W    = 4,
    parameter int AW   = 3,
    parameter int PC_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   dbg_sel,
    input logic [W-1:0]    dbg_val,
    input logic [PC_W-1:0] pc_o,
    input logic            ovf_o,
    input logic            zero_o,
    input logic [1:0]      op_bits,
    input logic [3:0]      fn_bits,
    input logic [PC_W-1:0] tgt_bits,
    input logic [W-1:0]    ra_val,
    input logic            wb_en
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && !ovf_o && !zero_o));

    a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
        !(op_bits == 2'b11 && ra_val == '0) |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));

    a_r7_jump_taken: assert property (@(posedge clk) disable iff (rst)
        (op_bits == 2'b11 && ra_val == '0) |=> pc_o == $past(tgt_bits));

    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (op_bits == 2'b00 && fn_bits == 4'b0111) |-> !wb_en);

    a_r6_flags_hold: assert property (@(posedge clk) disable iff (rst)
        op_bits[1] |=> $stable({ovf_o, zero_o}));

    a_r9_r0_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel == '0) |-> (dbg_val == '0));

endmodule

bind np_core np_core_chk #(.W(W), .AW(AW), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dbg_sel  (dbg_sel),
    .dbg_val  (dbg_val),
    .pc_o     (pc_o),
    .ovf_o    (ovf_o),
    .zero_o   (zero_o),
    .op_bits  (instr[IW-1:IW-2]),
    .fn_bits  (instr[3:0]),
    .tgt_bits (instr[PC_W-1:0]),
    .ra_val   (ra_val),
    .wb_en    (wb_en)
);

// File: tb/np_core_tb.sv
module np_core_tb;

    localparam int CLK_PERIOD = 10;

    // second program: logic ops, multiply, compare, multiply overflow
    localparam logic [95:0] PROG_B = {
        12'h095, 12'h0A3, 12'h127, 12'h125,
        12'h114, 12'h0A2, 12'h90A, 12'h88C
    };

    // row: pcA selA valA zA oA | pcB selB valB zB oB (state after each edge)
    localparam logic [23:0] VEC [8] = '{
        {3'd1, 3'd1, 4'd5,  1'b0, 1'b0,  3'd1, 3'd1, 4'd12, 1'b0, 1'b0},
        {3'd2, 3'd2, 4'd3,  1'b0, 1'b0,  3'd2, 3'd2, 4'd10, 1'b0, 1'b0},
        {3'd3, 3'd1, 4'd8,  1'b0, 1'b1,  3'd3, 3'd1, 4'd8,  1'b0, 1'b0},
        {3'd4, 3'd2, 4'd13, 1'b0, 1'b0,  3'd4, 3'd2, 4'd2,  1'b0, 1'b0},
        {3'd6, 3'd3, 4'd0,  1'b0, 1'b0,  3'd5, 3'd2, 4'd4,  1'b0, 1'b0},
        {3'd7, 3'd0, 4'd0,  1'b0, 1'b0,  3'd6, 3'd2, 4'd4,  1'b1, 1'b0},
        {3'd0, 3'd1, 4'd8,  1'b0, 1'b0,  3'd7, 3'd1, 4'd12, 1'b0, 1'b0},
        {3'd1, 3'd1, 4'd5,  1'b0, 1'b0,  3'd0, 3'd1, 4'd0,  1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel_a = '0, sel_b = '0;
    logic [3:0] val_a, val_b;
    logic [2:0] pc_a, pc_b;
    logic       ovf_a, ovf_b, zero_a, zero_b;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    np_core u_dut (
        .clk(clk), .rst(rst), .dbg_sel(sel_a), .dbg_val(val_a),
        .pc_o(pc_a), .ovf_o(ovf_a), .zero_o(zero_a)
    );

    np_core #(.PROGRAM(PROG_B)) u_dut_b (
        .clk(clk), .rst(rst), .dbg_sel(sel_b), .dbg_val(val_b),
        .pc_o(pc_b), .ovf_o(ovf_b), .zero_o(zero_b)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_cleared(input string tag);
        check({tag, " pc A"}, {5'd0, pc_a}, 8'd0);
        check({tag, " pc B"}, {5'd0, pc_b}, 8'd0);
        check({tag, " flags A"}, {6'd0, zero_a, ovf_a}, 8'd0);
        check({tag, " flags B"}, {6'd0, zero_b, ovf_b}, 8'd0);
        for (int r = 0; r < 8; r++) begin
            sel_a = 3'(r);
            sel_b = 3'(r);
            #1;
            check({tag, " reg A"}, {4'd0, val_a}, 8'd0);
            check({tag, " reg B"}, {4'd0, val_b}, 8'd0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_cleared("R1 power-up reset");
        rst = 1'b0;

        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            @(negedge clk);
            sel_a = VEC[i][20:18];
            sel_b = VEC[i][8:6];
            #1;
            check("R7/R8 pc A", {5'd0, pc_a}, {5'd0, VEC[i][23:21]});
            check("R7/R8 pc B", {5'd0, pc_b}, {5'd0, VEC[i][11:9]});
            check("R2/R3/R5/R9/R10 reg A", {4'd0, val_a}, {4'd0, VEC[i][17:14]});
            check("R3/R4/R10 reg B", {4'd0, val_b}, {4'd0, VEC[i][5:2]});
            check("R6 flags A", {6'd0, zero_a, ovf_a}, {6'd0, VEC[i][13], VEC[i][12]});
            check("R6 flags B", {6'd0, zero_b, ovf_b}, {6'd0, VEC[i][1], VEC[i][0]});
        end

        // R7: the load of R4 lies behind a taken jump and never executes
        sel_a = 3'd4;
        #1;
        check("R7 skipped write R4", {4'd0, val_a}, 8'd0);
        // R9: load of 9 into register 0 was discarded
        sel_a = 3'd0;
        #1;
        check("R9 register 0", {4'd0, val_a}, 8'd0);
        // R4: compare left register 2 at the multiply result
        sel_b = 3'd2;
        #1;
        check("R4 compare kept R2", {4'd0, val_b}, 8'd4);

        // R1: reset in mid-run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_cleared("R1 mid-run reset");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        sel_a = 3'd1;
        sel_b = 3'd1;
        #1;
        check("R8 pc after reset A", {5'd0, pc_a}, 8'd1);
        check("R2 reload after reset A", {4'd0, val_a}, 8'd5);
        check("R2 reload after reset B", {4'd0, val_b}, 8'd12);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule